// File: doc/BRIEF.md
# SD/MMC Command Path Sequencer

This block drives the command half of an SD/MMC host. A register-side request presents a 6-bit command index, a 32-bit argument, a flag word and a response timeout. The block then does one of two things. It can copy new clock-enable and clock-divider values into its clock registers and stop there. Or it can run a full command: an optional 80-clock initialization preamble on the CMD line, the 48-bit command frame with its CRC7, an optional 48-bit or 136-bit response capture with timeout detection, and finally an 8-clock command-to-command gap. At the end of the gap it pulses a done signal.

The block gates loading against the data path. When the wait-for-previous-data flag is set and a transfer of predefined length is running, the load is held off. An open-ended transfer, or no transfer at all, lets the command load at once. The data path can ask for an automatic stop command, which the block sends without a host request. A command can also wait for an interrupt-style response without a timeout. A release input ends that wait by making the host itself transmit a response frame whose RCA field is zero.

One CMD bit is sent or sampled per clock. The card clock divider, the data path and the card are outside the block and appear only as status inputs and the CMD line.

Top module: `sd_cmd_seq`

## Requirements
- R1: After reset the CMD line is released (`cmd_oe`=0), `clk_en`=0, `clk_div`=0, and no pulse output is high.
- R2: A request with flag bit 0 (clock-update-only) set is accepted, copies `req_clk_en` and `req_clk_div` to `clk_en` and `clk_div`, and drives nothing on CMD.
- R3: A command frame is 48 bits sent MSB first on `cmd_out` with `cmd_oe`=1. The bits are: start 0, direction 1, the index, the argument, CRC7 (x^7+x^3+1 over the first 40 bits) and end bit 1. Index 0 with argument 0 gives 0x400000000095.
- R4: With flag bit 2 (send-init) set, exactly 80 clocks with `cmd_oe`=1 and `cmd_out`=1 come before the start bit.
- R5: With flag bit 3 (response expected) set and bit 4 clear, the block waits for a 0 start bit and captures 48 bits into `resp_data[47:0]`. It pulses `resp_valid`, with `resp_crc_err`=0 when the CRC7 over the first 40 bits matches bits 7:1.
- R6: A 48-bit response whose CRC7 field does not match gives `resp_crc_err`=1 together with `resp_valid`.
- R7: With flag bits 3 and 4 set, 136 bits are captured into `resp_data[135:0]` and no CRC error is reported.
- R8: If no start bit is sampled within `req_tmo` clocks after the frame, `resp_timeout` pulses `req_tmo`+1 clocks after the last frame bit, and `resp_valid` does not pulse.
- R9: After the frame (no response), or after the response or timeout, CMD is driven high for 8 clocks, and then `cmd_done` pulses as the block goes idle.
- R10: With flag bit 1 (wait-for-previous-data) set, `data_busy`=1 and `data_open`=0, the request is not accepted until `data_busy` falls.
- R11: With flag bit 1 set, the request is accepted on the next edge when `data_open`=1 or `data_busy`=0. With flag bit 1 clear, a busy data path does not delay the request.
- R12: With flag bit 5 (interrupt wait) set, the response wait never times out. A pulse on `irq_release` while CMD is high makes the block send the frame {0, 0, index 40, argument 0, CRC7, 1}, followed by the gap and `cmd_done`.
- R13: A pulse on `autostop_req` makes the idle block send index 12 with argument 0 and capture a 48-bit response, without any `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CMD bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held until accepted |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_flags | input | 6 | [0] clock-update-only, [1] wait-for-data, [2] send-init, [3] response expected, [4] long response, [5] interrupt wait |
| req_tmo | input | TMO_W | Response timeout in clocks |
| req_clk_en | input | 1 | New clock-enable value |
| req_clk_div | input | DIV_W | New clock-divider value |
| req_accept | output | 1 | Pulse: request taken |
| clk_en | output | 1 | Clock-enable register |
| clk_div | output | DIV_W | Clock-divider register |
| data_busy | input | 1 | Data transfer in progress |
| data_open | input | 1 | Running transfer is open-ended (byte count zero) |
| autostop_req | input | 1 | Pulse: data path asks for a stop command |
| irq_release | input | 1 | Pulse: end an interrupt-mode response wait |
| cmd_in | input | 1 | Sampled CMD line |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| resp_data | output | 136 | Received response bits, last bit in bit 0 |
| resp_valid | output | 1 | Pulse: response captured |
| resp_crc_err | output | 1 | With resp_valid: 48-bit CRC mismatch |
| resp_timeout | output | 1 | Pulse: no start bit in time |
| cmd_done | output | 1 | Pulse: command finished, block idle |

## Verification
The bench builds the block with its default parameters: an 80-clock preamble, an 8-clock gap, a 16-bit timeout, stop index 12 and release index 40. With these values the exact preamble and gap lengths can be counted, and the frames can be compared with well-known CRC7 values. A short timeout of 20 clocks makes the timeout edge land at a cycle that can be predicted exactly. The 16-bit timeout is still wide enough to show that an interrupt-mode wait with a small timeout stays open for as long as the bench likes.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_TX,
        ST_RXW,
        ST_RXB,
        ST_GAP
    } seq_st_e;

    // bit 0 is upd_clk, bit 5 is irq_wait
    typedef struct packed {
        logic irq_wait;
        logic resp_long;
        logic resp_exp;
        logic send_init;
        logic wait_prev;
        logic upd_clk;
    } cmd_flags_t;

endpackage

// File: rtl/sd_crc7.sv
module sd_crc7 #(
    parameter int unsigned N = 40
) (
    input  logic [N-1:0] data,
    output logic [6:0]   crc
);
    always_comb begin
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = N - 1; i >= 0; i--) begin
            fb = data[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        crc = c;
    end
endmodule

// File: rtl/sd_load_gate.sv
module sd_load_gate (
    input  logic wait_prev,
    input  logic data_busy,
    input  logic data_open,
    output logic ok
);
    // predefined-length transfer in flight blocks a waiting load
    always_comb ok = !wait_prev || !data_busy || data_open;
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
    import sd_cmd_pkg::*;
#(
    parameter int unsigned TMO_W      = 16,
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned INIT_CLKS  = 80,
    parameter int unsigned GAP_CLKS   = 8,
    parameter int unsigned STOP_TMO   = 64,
    parameter int unsigned STOP_INDEX = 12,
    parameter int unsigned REL_INDEX  = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [5:0]         req_index,
    input  logic [31:0]        req_arg,
    input  logic [5:0]         req_flags,
    input  logic [TMO_W-1:0]   req_tmo,
    input  logic               req_clk_en,
    input  logic [DIV_W-1:0]   req_clk_div,
    output logic               req_accept,
    output logic               clk_en,
    output logic [DIV_W-1:0]   clk_div,
    input  logic               data_busy,
    input  logic               data_open,
    input  logic               autostop_req,
    input  logic               irq_release,
    input  logic               cmd_in,
    output logic               cmd_out,
    output logic               cmd_oe,
    output logic [135:0]       resp_data,
    output logic               resp_valid,
    output logic               resp_crc_err,
    output logic               resp_timeout,
    output logic               cmd_done
);
    localparam int unsigned FRAME_BITS = 48;
    localparam int unsigned SHORT_BITS = 48;
    localparam int unsigned LONG_BITS  = 136;
    localparam int unsigned SPAN       = INIT_CLKS + LONG_BITS + GAP_CLKS;
    localparam int unsigned CW_MIN     = $clog2(SPAN) + 1;
    localparam int unsigned CNT_W      = (TMO_W > CW_MIN) ? TMO_W : CW_MIN;

    typedef struct packed {
        seq_st_e              st;
        logic [FRAME_BITS-1:0] sh;
        logic [CNT_W-1:0]     cnt;
        logic [TMO_W-1:0]     tmo;
        logic                 rexp;
        logic                 rlong;
        logic                 irq;
        logic [LONG_BITS-1:0] rsh;
        logic                 clk_en;
        logic [DIV_W-1:0]     clk_div;
        logic                 auto_pend;
        logic                 accept;
        logic                 rvalid;
        logic                 crc_err;
        logic                 rtmo;
        logic                 done;
    } seq_t;

    seq_t       q, n;
    cmd_flags_t fl;
    logic       gate_ok;
    logic [39:0] tx_hdr;
    logic [6:0]  tx_crc;
    logic [6:0]  rx_crc;

    assign fl = cmd_flags_t'(req_flags);

    sd_load_gate u_gate (
        .wait_prev (fl.wait_prev),
        .data_busy (data_busy),
        .data_open (data_open),
        .ok        (gate_ok)
    );

    // header of whatever frame the next load would send
    always_comb begin
        if (q.st == ST_RXW)
            tx_hdr = {2'b00, 6'(REL_INDEX), 32'h0};
        else if (q.auto_pend)
            tx_hdr = {2'b01, 6'(STOP_INDEX), 32'h0};
        else
            tx_hdr = {2'b01, req_index, req_arg};
    end

    sd_crc7 #(.N(40)) u_tx_crc (.data(tx_hdr), .crc(tx_crc));
    // first 40 bits of a short response once the final bit arrives
    sd_crc7 #(.N(40)) u_rx_crc (.data(q.rsh[46:7]), .crc(rx_crc));

    always_comb begin
        n         = q;
        n.accept  = 1'b0;
        n.rvalid  = 1'b0;
        n.crc_err = 1'b0;
        n.rtmo    = 1'b0;
        n.done    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                n.cnt = '0;
                if (q.auto_pend) begin
                    n.auto_pend = 1'b0;
                    n.sh        = {tx_hdr, tx_crc, 1'b1};
                    n.rexp      = 1'b1;
                    n.rlong     = 1'b0;
                    n.irq       = 1'b0;
                    n.tmo       = TMO_W'(STOP_TMO);
                    n.st        = ST_TX;
                end else if (req_valid && gate_ok) begin
                    n.accept = 1'b1;
                    if (fl.upd_clk) begin
                        n.clk_en  = req_clk_en;
                        n.clk_div = req_clk_div;
                    end else begin
                        n.sh    = {tx_hdr, tx_crc, 1'b1};
                        n.rexp  = fl.resp_exp;
                        n.rlong = fl.resp_long;
                        n.irq   = fl.irq_wait;
                        n.tmo   = req_tmo;
                        n.st    = fl.send_init ? ST_INIT : ST_TX;
                    end
                end
            end
            ST_INIT: begin
                n.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(INIT_CLKS - 1)) begin
                    n.cnt = '0;
                    n.st  = ST_TX;
                end
            end
            ST_TX: begin
                n.sh  = {q.sh[FRAME_BITS-2:0], 1'b1};
                n.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                    n.cnt = '0;
                    n.st  = q.rexp ? ST_RXW : ST_GAP;
                end
            end
            ST_RXW: begin
                if (!cmd_in) begin
                    n.rsh = {q.rsh[LONG_BITS-2:0], 1'b0};
                    n.cnt = CNT_W'(1);
                    n.st  = ST_RXB;
                end else if (q.irq) begin
                    if (irq_release) begin
                        n.sh   = {tx_hdr, tx_crc, 1'b1};
                        n.rexp = 1'b0;
                        n.irq  = 1'b0;
                        n.cnt  = '0;
                        n.st   = ST_TX;
                    end
                end else if (q.cnt == CNT_W'(q.tmo) - CNT_W'(1)) begin
                    n.rtmo = 1'b1;
                    n.cnt  = '0;
                    n.st   = ST_GAP;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            ST_RXB: begin
                n.rsh = {q.rsh[LONG_BITS-2:0], cmd_in};
                n.cnt = q.cnt + 1'b1;
                if (q.cnt == (q.rlong ? CNT_W'(LONG_BITS - 1) : CNT_W'(SHORT_BITS - 1))) begin
                    n.rvalid  = 1'b1;
                    n.crc_err = !q.rlong && (rx_crc != q.rsh[6:0]);
                    n.cnt     = '0;
                    n.st      = ST_GAP;
                end
            end
            ST_GAP: begin
                n.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(GAP_CLKS - 1)) begin
                    n.cnt  = '0;
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                end
            end
            default: n.st = ST_IDLE;
        endcase
        if (autostop_req) n.auto_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.sh <= '1;
        end else begin
            q <= n;
        end
    end

    assign req_accept   = q.accept;
    assign clk_en       = q.clk_en;
    assign clk_div      = q.clk_div;
    assign cmd_oe       = (q.st == ST_INIT) || (q.st == ST_TX) || (q.st == ST_GAP);
    assign cmd_out      = (q.st == ST_TX) ? q.sh[FRAME_BITS-1] : 1'b1;
    assign resp_data    = q.rsh;
    assign resp_valid   = q.rvalid;
    assign resp_crc_err = q.crc_err;
    assign resp_timeout = q.rtmo;
    assign cmd_done     = q.done;

    AST_UPD_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !q.auto_pend && req_valid && gate_ok && fl.upd_clk)
        |=> (req_accept && !cmd_oe && clk_en == $past(req_clk_en))); // R2
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && req_valid && fl.wait_prev && data_busy && !data_open)
        |=> !req_accept); // R10
    AST_OPEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !q.auto_pend && req_valid && fl.wait_prev && data_busy && data_open)
        |=> req_accept); // R11
    AST_CRC_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        resp_crc_err |-> (resp_valid && !q.rlong)); // R6
    AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && resp_timeout)); // R8
    AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> ($past(cmd_oe) && $past(cmd_out) && !cmd_oe)); // R9
    AST_IRQ_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RXW && q.irq) |=> !resp_timeout); // R12
endmodule

// File: tb/sd_cmd_seq_tb.sv
module sd_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [5:0]   req_index = '0;
    logic [31:0]  req_arg = '0;
    logic [5:0]   req_flags = '0;
    logic [15:0]  req_tmo = '0;
    logic         req_clk_en = 1'b0;
    logic [7:0]   req_clk_div = '0;
    logic         req_accept, clk_en, cmd_out, cmd_oe;
    logic [7:0]   clk_div;
    logic         data_busy = 1'b0, data_open = 1'b0;
    logic         autostop_req = 1'b0, irq_release = 1'b0, cmd_in = 1'b1;
    logic [135:0] resp_data;
    logic         resp_valid, resp_crc_err, resp_timeout, cmd_done;

    int n_vec = 0, n_err = 0, cycles = 0;
    logic         got_rv = 0, got_crc = 0, got_to = 0;
    logic [135:0] rv_data = '0;

    sd_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .req_arg(req_arg), .req_flags(req_flags), .req_tmo(req_tmo),
        .req_clk_en(req_clk_en), .req_clk_div(req_clk_div), .req_accept(req_accept),
        .clk_en(clk_en), .clk_div(clk_div), .data_busy(data_busy), .data_open(data_open),
        .autostop_req(autostop_req), .irq_release(irq_release), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .resp_data(resp_data), .resp_valid(resp_valid),
        .resp_crc_err(resp_crc_err), .resp_timeout(resp_timeout), .cmd_done(cmd_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (resp_valid) begin got_rv = 1; got_crc = resp_crc_err; rv_data = resp_data; end
        if (resp_timeout) got_to = 1;
        if (cycles > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = d[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [47:0] mk48(input logic dir, input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h = {1'b0, dir, idx, arg};
        return {h, ref_crc(h), 1'b1};
    endfunction

    task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        got_rv = 0; got_crc = 0; got_to = 0;
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                         input logic [5:0] fl, input logic [15:0] tmo);
        @(negedge clk);
        req_index = idx; req_arg = arg; req_flags = fl; req_tmo = tmo; req_valid = 1;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (req_accept) break;
        end
        req_valid = 0;
    endtask

    // returns at the negedge of the last frame bit
    task automatic collect(output logic [47:0] fr, output int init_n);
        init_n = 0;
        for (int k = 0; k < 2000; k++) begin
            if (cmd_oe && !cmd_out) break;
            if (cmd_oe) init_n++;
            @(negedge clk);
        end
        fr[47] = cmd_out;
        for (int i = 46; i >= 0; i--) begin
            @(negedge clk);
            fr[i] = cmd_out;
        end
    endtask

    // counts driven-high cycles from the current negedge until cmd_done
    task automatic gap_count(output int g);
        g = 0;
        for (int k = 0; k < 500; k++) begin
            if (cmd_done) break;
            if (cmd_oe && cmd_out) g++;
            @(negedge clk);
        end
    endtask

    task automatic respond(input logic [135:0] bits, input int len);
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk);
            cmd_in = bits[i];
        end
        @(negedge clk);
        cmd_in = 1;
    endtask

    task automatic t_reset();
        chk("R1 oe", cmd_oe, 0);
        chk("R1 clk_en", clk_en, 0);
        chk("R1 clk_div", clk_div, 0);
        chk("R1 pulses", {req_accept, resp_valid, resp_timeout, cmd_done}, 0);
    endtask

    task automatic t_upd_clk();
        int oe_seen = 0;
        req_clk_en = 1; req_clk_div = 8'h2A;
        issue(6'd5, 32'hFFFF_0000, 6'b000001, 16'd10);
        chk("R2 clk_en", clk_en, 1);
        chk("R2 clk_div", clk_div, 8'h2A);
        for (int k = 0; k < 20; k++) begin
            if (cmd_oe) oe_seen++;
            @(negedge clk);
        end
        chk("R2 no bus drive", oe_seen, 0);
    endtask

    task automatic t_frame_noresp(input logic [5:0] idx, input logic [31:0] arg,
                                  input logic [47:0] exp);
        logic [47:0] fr; int ini, g;
        issue(idx, arg, 6'b000000, 16'd10);
        collect(fr, ini);
        chk("R3 frame", fr, exp);
        chk("R3 no preamble", ini, 0);
        @(negedge clk);
        gap_count(g);
        chk("R9 gap", g, 8);
    endtask

    task automatic t_init();
        logic [47:0] fr; int ini, g;
        issue(6'd0, 32'h0, 6'b000100, 16'd10);
        collect(fr, ini);
        chk("R4 preamble", ini, 80);
        chk("R4 frame", fr, 48'h40_0000_0000_95);
        @(negedge clk);
        gap_count(g);
    endtask

    task automatic t_short(input logic bad);
        logic [47:0] fr, rsp; int ini, g;
        logic [39:0] h;
        clear_mon();
        issue(6'd13, 32'h0001_0000, 6'b001000, 16'd100);
        collect(fr, ini);
        chk("R3 frame cmd13", fr, mk48(1'b1, 6'd13, 32'h0001_0000));
        h = {2'b00, 6'd13, 32'h0000_0900};
        rsp = {h, ref_crc(h) ^ (bad ? 7'h11 : 7'h00), 1'b1};
        repeat (3) @(negedge clk);
        respond({88'h0, rsp}, 48);
        gap_count(g);
        chk(bad ? "R6 valid" : "R5 valid", got_rv, 1);
        chk(bad ? "R6 crc_err" : "R5 crc_err", got_crc, bad);
        chk(bad ? "R6 data" : "R5 data", rv_data[47:0], rsp);
        chk("R9 gap after response", g, 8);
    endtask

    task automatic t_long();
        logic [47:0] fr; int ini, g;
        logic [135:0] rsp;
        clear_mon();
        rsp = {8'h3F, 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, 7'h5A, 1'b1};
        issue(6'd2, 32'h0, 6'b011000, 16'd100);
        collect(fr, ini);
        respond(rsp, 136);
        gap_count(g);
        chk("R7 valid", got_rv, 1);
        chk("R7 no crc err", got_crc, 0);
        chk("R7 data", rv_data, rsp);
    endtask

    task automatic t_timeout();
        logic [47:0] fr; int ini, g, k;
        clear_mon();
        issue(6'd8, 32'h1AA, 6'b001000, 16'd20);
        collect(fr, ini);
        k = 0;
        for (int j = 0; j < 200; j++) begin
            @(negedge clk);
            k++;
            if (resp_timeout) break;
        end
        chk("R8 timeout cycle", k, 21);
        gap_count(g);
        chk("R8 no valid", got_rv, 0);
        chk("R9 gap after timeout", g, 8);
    endtask

    task automatic t_gate_hold();
        logic [47:0] fr; int ini, g, acc = 0, oe = 0, k;
        data_busy = 1; data_open = 0;
        @(negedge clk);
        req_index = 6'd17; req_arg = 32'h0; req_flags = 6'b000010; req_valid = 1;
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            if (req_accept) acc++;
            if (cmd_oe) oe++;
        end
        chk("R10 held accept", acc, 0);
        chk("R10 held bus", oe, 0);
        data_busy = 0;
        k = 0;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            k++;
            if (req_accept) break;
        end
        req_valid = 0;
        chk("R10 released", k, 1);
        collect(fr, ini);
        chk("R10 frame", fr, 48'h51_0000_0000_55);
        @(negedge clk);
        gap_count(g);
    endtask

    task automatic t_gate_pass(input logic [5:0] fl, input logic open);
        logic [47:0] fr; int ini, g;
        data_busy = 1; data_open = open;
        @(negedge clk);
        req_index = 6'd0; req_arg = 32'h0; req_flags = fl; req_valid = 1;
        @(negedge clk);
        chk("R11 immediate accept", req_accept, 1);
        req_valid = 0;
        collect(fr, ini);
        @(negedge clk);
        gap_count(g);
        data_busy = 0; data_open = 0;
    endtask

    task automatic t_irq();
        logic [47:0] fr; int ini, g;
        clear_mon();
        issue(6'd40, 32'h0, 6'b101000, 16'd5);
        collect(fr, ini);
        repeat (50) @(negedge clk);
        chk("R12 no timeout", got_to, 0);
        irq_release = 1;
        @(negedge clk);
        irq_release = 0;
        collect(fr, ini);
        chk("R12 release frame", fr, mk48(1'b0, 6'd40, 32'h0));
        @(negedge clk);
        gap_count(g);
        chk("R12 gap then done", g, 8);
    endtask

    task automatic t_autostop();
        logic [47:0] fr, rsp; int ini, g;
        logic [39:0] h;
        clear_mon();
        @(negedge clk);
        autostop_req = 1;
        @(negedge clk);
        autostop_req = 0;
        collect(fr, ini);
        chk("R13 stop frame", fr, mk48(1'b1, 6'd12, 32'h0));
        h = {2'b00, 6'd12, 32'h0000_0B00};
        rsp = {h, ref_crc(h), 1'b1};
        respond({88'h0, rsp}, 48);
        gap_count(g);
        chk("R13 response", got_rv, 1);
        chk("R13 data", rv_data[47:0], rsp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_upd_clk();
        t_frame_noresp(6'd0, 32'h0, 48'h40_0000_0000_95);
        t_frame_noresp(6'd17, 32'h0, 48'h51_0000_0000_55);
        t_init();
        t_short(1'b0);
        t_short(1'b1);
        t_long();
        t_timeout();
        t_gate_hold();
        t_gate_pass(6'b000010, 1'b1);
        t_gate_pass(6'b000000, 1'b0);
        t_irq();
        t_autostop();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule